// File: doc/BRIEF.md
# Gated Read-Write Cycle Sequencer

This block runs a tile array through one fixed flash cycle at a time. A flash cycle has five sub-phases in a fixed order: read, turnaround, write, readout sample and autoreset. Each sub-phase lasts a set number of clocks. During the cycle the block produces one strobe per phase for the tiles. It also controls which side drives the shared 16-lane bus. The conductor side drives during the read phase. Both sides release the bus during turnaround. Only the island side drives during the write phase. On the last clock of the write phase the block captures the lower eight 16-bit bus lanes as the readout.

The block takes commands over a valid/ready handshake. There are four opcodes: flash, domain clear with a domain mask, configuration apply, and a reserved code. A flash or a domain clear is refused until a configuration has been applied; such a refusal changes nothing. The external validator's verdict comes in on `cfg_ok_i`. A domain clear sends a one-clock clear pulse to every tile whose 4-bit domain id selects a set bit of the mask. The autoreset phase can send the same kind of pulse, using a mask supplied by the tile array. A 32-bit status word records whether the last cycle completed, and whether any overflow or collision was seen during it.

Top module: `rw_cycle_seq`

## Requirements
- R1: While `applied_o` is 0, an accepted flash (op 0) or domain clear (op 1) gives `rsp_valid_o` for one clock with code 1 in the next clock. No phase starts, no `tile_clr_o` bit pulses, and `applied_o` stays 0.
- R2: An accepted flash with `applied_o`=1 starts the read phase in the next clock. The phases then run read, turn, write, sample, auto, each for its parameter length of clocks, with exactly one phase strobe high at a time.
- R3: `cond_oe_o` is high only in the read phase and `isl_oe_o` only in the write phase. Both are low during turnaround, and they are never high together.
- R4: On the last clock of the write phase, `readout_o` captures bus lanes 0 to 7. Lane k is `bus_i[16k+15:16k]`. At all other times `readout_o` holds its value. It is zero after reset.
- R5: An accepted domain clear with mask m and `applied_o`=1 pulses `tile_clr_o[t]` for one clock for each tile t whose id d (`dom_id_i[4t+3:4t]`) has bit d of m set, and responds with code 0.
- R6: `cmd_ready_o` is low from the clock after a flash is accepted until the cycle ends. A command presented in that time is held off, not lost, and is accepted once ready returns.
- R7: An accepted apply (op 2) with `cfg_ok_i`=1 pulses every `tile_clr_o` bit, sets `applied_o` for good, and responds with code 0. With `cfg_ok_i`=0 it responds with code 2 and changes nothing.
- R8: At the entry to the auto phase, if `auto_en_i` is 1, `tile_clr_o` pulses for one clock for the tiles that `auto_mask_i` selects, decoded as in R5. If `auto_en_i` is 0, no bit pulses.
- R9: `flags_o` is zero after reset and changes only when a cycle ends. Bit 0 becomes 1. Bit 1 becomes the OR of `ovf_i` and bit 2 the OR of `collide_i`, each sampled over the read through sample phases. Bits 31:3 stay 0.
- R10: In the clock after the auto phase ends, `done_o`, `rsp_valid_o` (code 0) and `cmd_ready_o` are all high, and `done_o` lasts one clock.
- R11: The reserved op 3 responds with code 3 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Sequencer idle, command taken this edge |
| cmd_op_i | input | 2 | 0 flash, 1 domain clear, 2 apply, 3 reserved |
| cmd_mask_i | input | 16 | Domain mask for domain clear |
| cfg_ok_i | input | 1 | Staged configuration passed validation |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_code_o | output | 2 | 0 ok, 1 not applied, 2 rejected, 3 bad op |
| applied_o | output | 1 | A configuration has been applied |
| dom_id_i | input | 32 | 4-bit domain id per tile |
| tile_clr_o | output | 8 | One-clock runtime clear per tile |
| auto_en_i | input | 1 | Enable autoreset for this cycle |
| auto_mask_i | input | 16 | Domain mask for autoreset |
| ovf_i | input | 1 | Overflow seen by the tiles |
| collide_i | input | 1 | Collision seen by the tiles |
| ph_read_o | output | 1 | Read phase strobe |
| ph_turn_o | output | 1 | Turnaround strobe |
| ph_write_o | output | 1 | Write phase strobe |
| ph_sample_o | output | 1 | Readout sample strobe |
| ph_auto_o | output | 1 | Autoreset phase strobe |
| cond_oe_o | output | 1 | Conductor drives the bus |
| isl_oe_o | output | 1 | Island drives the bus |
| bus_i | input | 256 | Sixteen 16-bit bus lanes |
| readout_o | output | 128 | Captured lanes 0 to 7 |
| flags_o | output | 32 | Last-cycle status word |
| done_o | output | 1 | Cycle-complete pulse |

## Verification
The bench sends refused commands before any apply. A design that lets a flash or clear through at that point would start phases or pulse `tile_clr_o`. It presents commands while a cycle is busy; a design that drops them, or acts on them mid-cycle, would miss a response or send a clear too early. It changes the bus during the write phase, so a design that captures one clock early or late shows a different readout. It also raises overflow and collision only in some phases, so a design that samples outside the read-to-sample window reports the wrong flag bits. Domain ids are spread over many values and masks hit single, alternating and no domains, so an off-by-one in the mask decode shows up.

// File: rtl/rwseq_pkg.sv
package rwseq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_READ, PH_TURN, PH_WRITE, PH_SAMPLE, PH_AUTO
  } phase_e;

  typedef enum logic [1:0] {
    OP_FLASH, OP_DOMCLR, OP_APPLY, OP_RSVD
  } op_e;

  typedef enum logic [1:0] {
    RSP_OK, RSP_NOT_APPLIED, RSP_CFG_REJECT, RSP_BAD_OP
  } rsp_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int clamp1(input int a);
    return (a < 1) ? 1 : a;
  endfunction
endpackage

// File: rtl/rwseq_phase_timer.sv
module rwseq_phase_timer
  import rwseq_pkg::*;
#(
  parameter int RD_LEN = 2,
  parameter int TA_LEN = 1,
  parameter int WR_LEN = 3,
  parameter int SM_LEN = 1,
  parameter int AR_LEN = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output phase_e phase_o,
  output logic   last_o
);
  localparam int RD_L    = clamp1(RD_LEN);
  localparam int TA_L    = clamp1(TA_LEN);
  localparam int WR_L    = clamp1(WR_LEN);
  localparam int SM_L    = clamp1(SM_LEN);
  localparam int AR_L    = clamp1(AR_LEN);
  localparam int MAX_L   = imax(imax(imax(RD_L, TA_L), imax(WR_L, SM_L)), AR_L);
  localparam int CNT_W   = (MAX_L < 2) ? 1 : $clog2(MAX_L);

  phase_e           phase_q, phase_nx;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim      = '0;
    phase_nx = PH_IDLE;
    unique case (phase_q)
      PH_READ:   begin lim = CNT_W'(RD_L - 1); phase_nx = PH_TURN;   end
      PH_TURN:   begin lim = CNT_W'(TA_L - 1); phase_nx = PH_WRITE;  end
      PH_WRITE:  begin lim = CNT_W'(WR_L - 1); phase_nx = PH_SAMPLE; end
      PH_SAMPLE: begin lim = CNT_W'(SM_L - 1); phase_nx = PH_AUTO;   end
      PH_AUTO:   begin lim = CNT_W'(AR_L - 1); phase_nx = PH_IDLE;   end
      default:   begin lim = '0;               phase_nx = PH_IDLE;   end
    endcase
  end

  assign last_o  = (phase_q != PH_IDLE) && (cnt_q == lim);
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (phase_q == PH_IDLE) begin
      if (start_i) begin
        phase_q <= PH_READ;
        cnt_q   <= '0;
      end
    end else if (last_o) begin
      phase_q <= phase_nx;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rwseq_dom_decode.sv
module rwseq_dom_decode #(
  parameter int NUM_TILES = 8,
  parameter int DOM_W     = 4,
  localparam int MASK_W   = 1 << DOM_W
) (
  input  logic [NUM_TILES*DOM_W-1:0] dom_id_i,
  input  logic [MASK_W-1:0]          mask_i,
  output logic [NUM_TILES-1:0]       hit_o
);
  for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
    assign hit_o[t] = mask_i[dom_id_i[t*DOM_W +: DOM_W]];
  end
endmodule

// File: rtl/rwseq_readout.sv
module rwseq_readout #(
  parameter int BUS_LANES = 16,
  parameter int RD_LANES  = 8,
  parameter int LVL_W     = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       capture_i,
  input  logic [BUS_LANES*LVL_W-1:0] bus_i,
  output logic [RD_LANES*LVL_W-1:0]  readout_o
);
  for (genvar k = 0; k < RD_LANES; k++) begin : g_lane
    logic [LVL_W-1:0] lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lvl_q <= '0;
      else if (capture_i) lvl_q <= bus_i[k*LVL_W +: LVL_W];
    end
    assign readout_o[k*LVL_W +: LVL_W] = lvl_q;
  end
endmodule

// File: rtl/rw_cycle_seq.sv
module rw_cycle_seq
  import rwseq_pkg::*;
#(
  parameter int NUM_TILES = 8,
  parameter int DOM_W     = 4,
  parameter int BUS_LANES = 16,
  parameter int RD_LANES  = 8,
  parameter int LVL_W     = 16,
  parameter int RD_LEN    = 2,
  parameter int TA_LEN    = 1,
  parameter int WR_LEN    = 3,
  parameter int SM_LEN    = 1,
  parameter int AR_LEN    = 2,
  localparam int MASK_W   = 1 << DOM_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cmd_valid_i,
  output logic                           cmd_ready_o,
  input  logic [1:0]                     cmd_op_i,
  input  logic [MASK_W-1:0]              cmd_mask_i,
  input  logic                           cfg_ok_i,
  output logic                           rsp_valid_o,
  output logic [1:0]                     rsp_code_o,
  output logic                           applied_o,
  input  logic [NUM_TILES*DOM_W-1:0]     dom_id_i,
  output logic [NUM_TILES-1:0]           tile_clr_o,
  input  logic                           auto_en_i,
  input  logic [MASK_W-1:0]              auto_mask_i,
  input  logic                           ovf_i,
  input  logic                           collide_i,
  output logic                           ph_read_o,
  output logic                           ph_turn_o,
  output logic                           ph_write_o,
  output logic                           ph_sample_o,
  output logic                           ph_auto_o,
  output logic                           cond_oe_o,
  output logic                           isl_oe_o,
  input  logic [BUS_LANES*LVL_W-1:0]     bus_i,
  output logic [RD_LANES*LVL_W-1:0]      readout_o,
  output logic [31:0]                    flags_o,
  output logic                           done_o
);
  phase_e               phase;
  logic                 last;
  logic                 accept, start;
  op_e                  op;
  logic                 applied_q;
  rsp_e                 rsp_q;
  logic                 rsp_v_q, done_q;
  logic [NUM_TILES-1:0] clr_q, cmd_hit, auto_hit;
  logic                 ovf_acc_q, col_acc_q;
  logic [31:0]          flags_q;
  logic                 in_window;

  assign op          = op_e'(cmd_op_i);
  assign cmd_ready_o = (phase == PH_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign start       = accept && (op == OP_FLASH) && applied_q;
  assign in_window   = (phase == PH_READ) || (phase == PH_TURN) ||
                       (phase == PH_WRITE) || (phase == PH_SAMPLE);

  rwseq_phase_timer #(
    .RD_LEN(RD_LEN), .TA_LEN(TA_LEN), .WR_LEN(WR_LEN),
    .SM_LEN(SM_LEN), .AR_LEN(AR_LEN)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .phase_o (phase),
    .last_o  (last)
  );

  rwseq_dom_decode #(.NUM_TILES(NUM_TILES), .DOM_W(DOM_W)) u_cmd_dec (
    .dom_id_i (dom_id_i),
    .mask_i   (cmd_mask_i),
    .hit_o    (cmd_hit)
  );

  rwseq_dom_decode #(.NUM_TILES(NUM_TILES), .DOM_W(DOM_W)) u_auto_dec (
    .dom_id_i (dom_id_i),
    .mask_i   (auto_mask_i),
    .hit_o    (auto_hit)
  );

  rwseq_readout #(
    .BUS_LANES(BUS_LANES), .RD_LANES(RD_LANES), .LVL_W(LVL_W)
  ) u_readout (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i ((phase == PH_WRITE) && last),
    .bus_i     (bus_i),
    .readout_o (readout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      applied_q <= 1'b0;
      rsp_q     <= RSP_OK;
      rsp_v_q   <= 1'b0;
      done_q    <= 1'b0;
      clr_q     <= '0;
      ovf_acc_q <= 1'b0;
      col_acc_q <= 1'b0;
      flags_q   <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      done_q  <= 1'b0;
      clr_q   <= '0;
      if (accept) begin
        rsp_v_q <= 1'b1;
        unique case (op)
          OP_FLASH: begin
            if (applied_q) begin
              rsp_v_q   <= 1'b0;  // answered at cycle end
              ovf_acc_q <= 1'b0;
              col_acc_q <= 1'b0;
            end else begin
              rsp_q <= RSP_NOT_APPLIED;
            end
          end
          OP_DOMCLR: begin
            if (applied_q) begin
              clr_q <= cmd_hit;
              rsp_q <= RSP_OK;
            end else begin
              rsp_q <= RSP_NOT_APPLIED;
            end
          end
          OP_APPLY: begin
            if (cfg_ok_i) begin
              clr_q     <= '1;
              applied_q <= 1'b1;
              rsp_q     <= RSP_OK;
            end else begin
              rsp_q <= RSP_CFG_REJECT;
            end
          end
          default: rsp_q <= RSP_BAD_OP;
        endcase
      end
      if (in_window) begin
        ovf_acc_q <= ovf_acc_q | ovf_i;
        col_acc_q <= col_acc_q | collide_i;
      end
      if ((phase == PH_SAMPLE) && last && auto_en_i) clr_q <= auto_hit;
      if ((phase == PH_AUTO) && last) begin
        done_q  <= 1'b1;
        rsp_v_q <= 1'b1;
        rsp_q   <= RSP_OK;
        flags_q <= {29'd0, col_acc_q, ovf_acc_q, 1'b1};
      end
    end
  end

  assign rsp_valid_o = rsp_v_q;
  assign rsp_code_o  = rsp_q;
  assign applied_o   = applied_q;
  assign tile_clr_o  = clr_q;
  assign flags_o     = flags_q;
  assign done_o      = done_q;
  assign ph_read_o   = (phase == PH_READ);
  assign ph_turn_o   = (phase == PH_TURN);
  assign ph_write_o  = (phase == PH_WRITE);
  assign ph_sample_o = (phase == PH_SAMPLE);
  assign ph_auto_o   = (phase == PH_AUTO);
  assign cond_oe_o   = ph_read_o;
  assign isl_oe_o    = ph_write_o;
endmodule

// File: rtl/rw_cycle_seq_chk.sv
module rw_cycle_seq_chk #(
  parameter int NUM_TILES = 8,
  parameter int RO_W      = 128
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cmd_valid_i,
  input logic                 cmd_ready_o,
  input logic [1:0]           cmd_op_i,
  input logic                 cfg_ok_i,
  input logic                 rsp_valid_o,
  input logic [1:0]           rsp_code_o,
  input logic                 applied_o,
  input logic [NUM_TILES-1:0] tile_clr_o,
  input logic                 ph_read_o,
  input logic                 ph_turn_o,
  input logic                 ph_write_o,
  input logic                 ph_sample_o,
  input logic                 ph_auto_o,
  input logic                 cond_oe_o,
  input logic                 isl_oe_o,
  input logic [RO_W-1:0]      readout_o,
  input logic [31:0]          flags_o,
  input logic                 done_o
);
  assert_refuse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && !applied_o && (cmd_op_i <= 2'd1)) |=>
      (rsp_valid_o && rsp_code_o == 2'd1 && cmd_ready_o && tile_clr_o == '0));

  assert_strobe_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ph_read_o, ph_turn_o, ph_write_o, ph_sample_o, ph_auto_o}));

  assert_write_after_turn_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_write_o && !$past(ph_write_o)) |-> $past(ph_turn_o));

  assert_turn_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_turn_o |-> (!cond_oe_o && !isl_oe_o));

  assert_oe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cond_oe_o && isl_oe_o));

  assert_readout_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ph_write_o) |-> $stable(readout_o));

  assert_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_ready_o |-> $countones({ph_read_o, ph_turn_o, ph_write_o, ph_sample_o, ph_auto_o}) == 1);

  assert_apply_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && cmd_op_i == 2'd2 && cfg_ok_i) |=>
      (applied_o && &tile_clr_o && rsp_code_o == 2'd0));

  assert_applied_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(applied_o) |-> applied_o);

  assert_flags_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(flags_o));

  assert_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cmd_ready_o && flags_o[0] && rsp_valid_o && rsp_code_o == 2'd0 && $past(ph_auto_o)));

  assert_bad_op_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && cmd_op_i == 2'd3) |=>
      (rsp_valid_o && rsp_code_o == 2'd3 && tile_clr_o == '0 && cmd_ready_o));
endmodule

bind rw_cycle_seq rw_cycle_seq_chk #(
  .NUM_TILES(NUM_TILES), .RO_W(RD_LANES*LVL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_op_i    (cmd_op_i),
  .cfg_ok_i    (cfg_ok_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_code_o  (rsp_code_o),
  .applied_o   (applied_o),
  .tile_clr_o  (tile_clr_o),
  .ph_read_o   (ph_read_o),
  .ph_turn_o   (ph_turn_o),
  .ph_write_o  (ph_write_o),
  .ph_sample_o (ph_sample_o),
  .ph_auto_o   (ph_auto_o),
  .cond_oe_o   (cond_oe_o),
  .isl_oe_o    (isl_oe_o),
  .readout_o   (readout_o),
  .flags_o     (flags_o),
  .done_o      (done_o)
);

// File: tb/rw_cycle_seq_tb.sv
module rw_cycle_seq_tb;
  localparam int NT = 8;
  localparam int L_RD = 2, L_TA = 1, L_WR = 3, L_SM = 1, L_AR = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [1:0]   cmd_op = 2'd0;
  logic [15:0]  cmd_mask = '0;
  logic         cfg_ok = 1'b0;
  logic         rsp_valid;
  logic [1:0]   rsp_code;
  logic         applied;
  logic [31:0]  dom_id = '0;
  logic [NT-1:0] tile_clr;
  logic         auto_en = 1'b0;
  logic [15:0]  auto_mask = '0;
  logic         ovf = 1'b0, collide = 1'b0;
  logic         ph_rd, ph_ta, ph_wr, ph_sm, ph_ar, cond_oe, isl_oe;
  logic [255:0] bus = '0;
  logic [127:0] readout;
  logic [31:0]  flags;
  logic         done;

  int  checks = 0, fails = 0, cyc = 0;
  bit  noise_on = 1'b0;
  int  ovf_rate = 0;

  always #2.5 clk = ~clk;

  rw_cycle_seq #(
    .RD_LEN(L_RD), .TA_LEN(L_TA), .WR_LEN(L_WR), .SM_LEN(L_SM), .AR_LEN(L_AR)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_mask_i(cmd_mask), .cfg_ok_i(cfg_ok),
    .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code), .applied_o(applied),
    .dom_id_i(dom_id), .tile_clr_o(tile_clr), .auto_en_i(auto_en),
    .auto_mask_i(auto_mask), .ovf_i(ovf), .collide_i(collide),
    .ph_read_o(ph_rd), .ph_turn_o(ph_ta), .ph_write_o(ph_wr),
    .ph_sample_o(ph_sm), .ph_auto_o(ph_ar), .cond_oe_o(cond_oe),
    .isl_oe_o(isl_oe), .bus_i(bus), .readout_o(readout), .flags_o(flags),
    .done_o(done)
  );

  // reference model state
  int           m_ph = 0, m_cnt = 0;
  bit           m_app = 0, m_rv = 0, m_done = 0, m_ov = 0, m_co = 0;
  int           m_rc = 0;
  logic [NT-1:0] m_clr = '0;
  logic [127:0] m_ro = '0;
  logic [31:0]  m_flags = '0;

  function automatic int plen(input int p);
    case (p)
      1: return L_RD;
      2: return L_TA;
      3: return L_WR;
      4: return L_SM;
      default: return L_AR;
    endcase
  endfunction

  function automatic logic [NT-1:0] hits(input logic [15:0] m);
    logic [NT-1:0] h;
    for (int t = 0; t < NT; t++) h[t] = m[dom_id[t*4 +: 4]];
    return h;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_app = 0; m_rv = 0; m_done = 0; m_ov = 0; m_co = 0;
      m_rc = 0; m_clr = '0; m_ro = '0; m_flags = '0;
    end else begin
      bit last;
      m_clr = '0; m_rv = 0; m_done = 0;
      if (m_ph == 0) begin
        if (cmd_valid) begin
          m_rv = 1;
          case (cmd_op)
            2'd0: if (m_app) begin m_rv = 0; m_ph = 1; m_cnt = 0; m_ov = 0; m_co = 0; end
                  else m_rc = 1;
            2'd1: if (m_app) begin m_clr = hits(cmd_mask); m_rc = 0; end else m_rc = 1;
            2'd2: if (cfg_ok) begin m_clr = '1; m_app = 1; m_rc = 0; end else m_rc = 2;
            default: m_rc = 3;
          endcase
        end
      end else begin
        if (m_ph <= 4) begin m_ov |= ovf; m_co |= collide; end
        last = (m_cnt == plen(m_ph) - 1);
        if (m_ph == 3 && last) m_ro = bus[127:0];
        if (m_ph == 4 && last && auto_en) m_clr = hits(auto_mask);
        if (last) begin
          if (m_ph == 5) begin
            m_done = 1; m_rv = 1; m_rc = 0;
            m_flags = {29'd0, m_co, m_ov, 1'b1};
            m_ph = 0;
          end else m_ph++;
          m_cnt = 0;
        end else m_cnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 ready", cmd_ready, m_ph == 0);
      chk("R2 strobes", {ph_rd, ph_ta, ph_wr, ph_sm, ph_ar},
          {m_ph == 1, m_ph == 2, m_ph == 3, m_ph == 4, m_ph == 5});
      chk("R3 bus direction", {cond_oe, isl_oe}, {m_ph == 1, m_ph == 3});
      chk("R4 readout", readout, m_ro);
      chk("R5 R7 R8 tile clear", tile_clr, m_clr);
      chk("R1 R7 R11 response", {rsp_valid, rsp_code}, {m_rv, m_rc[1:0]});
      chk("R7 applied", applied, m_app);
      chk("R9 flags", flags, m_flags);
      chk("R10 done", done, m_done);
    end
  end

  // input noise: bus, status and autoreset mask change every clock
  always @(negedge clk) begin
    if (noise_on) begin
      for (int k = 0; k < 8; k++) bus[k*32 +: 32] = $urandom;
      ovf       = (ovf_rate != 0) && (($urandom % ovf_rate) == 0);
      collide   = (ovf_rate != 0) && (($urandom % (ovf_rate + 1)) == 0);
      auto_mask = 16'($urandom);
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  task automatic send(input logic [1:0] op, input logic [15:0] m);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_mask = m;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  initial begin
    for (int t = 0; t < NT; t++) dom_id[t*4 +: 4] = 4'((t * 5 + 1) % 16);
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset flags", flags, 32'd0);
    chk("R4 reset readout", readout, 128'd0);
    chk("R1 reset applied", applied, 1'b0);
    chk("R6 reset ready", cmd_ready, 1'b1);

    // R1: refused before apply
    send(2'd0, 16'h0);
    send(2'd1, 16'hFFFF);
    idle(2);
    chk("R1 no cycle after refused flash", {ph_rd, tile_clr}, '0);
    // R11
    send(2'd3, 16'hFFFF);
    // R7: rejected, then accepted apply
    cfg_ok = 1'b0; send(2'd2, 16'h0);
    idle(1);
    chk("R7 rejected apply keeps flag", applied, 1'b0);
    cfg_ok = 1'b1; send(2'd2, 16'h0);
    idle(1);
    chk("R7 apply sets flag", applied, 1'b1);

    // R5: domain clear masks
    send(2'd1, 16'h0001);
    send(2'd1, 16'h8000);
    send(2'd1, 16'hAAAA);
    send(2'd1, 16'h0F0F);
    send(2'd1, 16'h0000);
    send(2'd1, 16'h0842);

    // R2 R4 R8 R9: flashes with varied noise
    noise_on = 1'b1;
    for (int i = 0; i < 8; i++) begin
      auto_en  = i[0];
      ovf_rate = (i < 2) ? 0 : i;
      send(2'd0, 16'h0);
      wait_ready();
      idle(i % 3);
    end

    // R6: commands presented while busy are held off
    auto_en = 1'b1;
    send(2'd0, 16'h0);
    send(2'd1, 16'h3C3C);
    send(2'd0, 16'h0);
    send(2'd3, 16'h0);
    send(2'd0, 16'h0);
    cfg_ok = 1'b0;
    send(2'd2, 16'h0);
    cfg_ok = 1'b1;
    send(2'd2, 16'h0);
    // back-to-back flashes
    for (int i = 0; i < 6; i++) send(2'd0, 16'h0);
    wait_ready();
    noise_on = 1'b0;
    idle(4);
    chk("R10 idle at end", {cmd_ready, done}, 2'b10);
    finish_run();
  end
endmodule